// File: doc/BRIEF.md
# SD Host Transfer Command Sequencer

This block keeps the transfer-mode settings of an SD host and runs the command sequence that surrounds one block data transfer. Software loads a mode word, a main command argument, a separate argument for the count-setting command, and a block count. It then writes the upper byte of the command word, which starts a sequence. From the mode word and the block count, the sequencer works out whether the transfer is a single block, an endless stream, a counted run or an empty counted run. If the mode asks for it, it first sends a count-setting command (index 23) and waits for that command's response. It then sends the main command and follows the per-block strobes from the data engine. After the last block of a counted run it can send a stop command (index 12).

Commands leave the block on a valid/ready handshake. `cmd_valid` is raised with `cmd_index` and `cmd_arg` and stays high, with both fields unchanged, until the cycle in which `cmd_ready` is also high. The command engine applies back-pressure by holding `cmd_ready` low for as long as it needs. Responses come back as a single-cycle `rsp_valid` with an error flag. The block only takes a response while it is waiting for one for an automatic command, so the main command's response is not its concern.

Top module: `sd_xfer_seq`

## Requirements
- R1: After reset the mode readback, the block count, `busy`, `cmd_valid`, `acmd_err`, `xfer_done`, `dma_start` and `illegal_acmd` are all zero.
- R2: The mode word holds six bits: bit 5 multi-block select, bit 4 read direction (1 = card to host), bits 3:2 auto-command selection, bit 1 count enable and bit 0 DMA enable. `mode_q[15:6]` always reads 0. With `DMA_SUPPORT` = 0, bit 0 always reads 0.
- R3: Register writes take effect only when `busy` is 0. While `busy` is 1, writes to every register (select 0 mode, 1 command, 2 main argument, 3 block count, 4 count-command argument) are ignored.
- R4: `xfer_type` reads 0 (single) when multi-select is 0, 1 (endless) when multi-select is 1 and count enable is 0, 2 (counted) when both are 1 and the count is nonzero, and 3 (empty counted) when both are 1 and the count is 0.
- R5: A write to select 1 with byte enable 1 set starts a sequence. `busy` rises on the next edge and the command index is taken from data bits 13:8. A write to select 1 without byte enable 1 starts nothing.
- R6: With auto selection 2, the block first issues index 23 carrying the select-4 argument. After an error-free response it issues the main command carrying the select-2 argument. The command index is not checked.
- R7: If the index-23 response has its error flag set, the main command is never issued, `acmd_err[0]` is set and the sequence ends.
- R8: In a counted transfer each block strobe lowers the block count by one. When the count reaches 0, auto selection 1 issues index 12 with argument 0 and waits for its response; any other selection ends the sequence. An error in that response sets `acmd_err[1]`. Both `acmd_err` bits clear when the next sequence starts.
- R9: A single transfer ends after one block strobe. An endless transfer leaves the count unchanged and ends only on `stop_req`. An empty counted transfer ends as soon as its main command is accepted.
- R10: Writing auto selection 3 raises `illegal_acmd` for one cycle, on the edge after the write. The sequence then runs as if auto commands were disabled.
- R11: While `cmd_valid` is 1 and `cmd_ready` is 0, `cmd_valid`, `cmd_index` and `cmd_arg` hold steady on the next cycle.
- R12: `dma_start` pulses for one cycle, on the edge that starts a sequence, when the DMA enable bit is 1.
- R13: `xfer_done` is a one-cycle pulse at the end of every sequence, and `busy` falls on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 3 | Register select |
| reg_wr_data | input | 32 | Write data |
| reg_wr_be | input | 4 | Byte enables |
| mode_q | output | 16 | Mode word readback |
| blk_cnt | output | 16 | Current block count |
| xfer_type | output | 2 | Decoded transfer type |
| busy | output | 1 | Command-inhibit flag, high for the whole sequence |
| cmd_valid | output | 1 | Command request valid |
| cmd_ready | input | 1 | Command engine accepts the request |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| rsp_valid | input | 1 | Response strobe |
| rsp_err | input | 1 | Response carries an error |
| blk_done | input | 1 | One block finished on the data lines |
| stop_req | input | 1 | External end of an endless transfer |
| dma_start | output | 1 | DMA start pulse |
| xfer_done | output | 1 | Sequence-complete pulse |
| acmd_err | output | 2 | Sticky errors: bit 0 count command, bit 1 stop command |
| illegal_acmd | output | 1 | Reserved auto selection was written |

## Verification
The hardest situations to reach are the failure paths of the automatic commands. These are an index-23 response with an error, which must suppress the main command, and an index-12 error that arrives only after the last block of a counted run. The bench acts as the command engine and the data engine. It accepts each request after a programmable number of stall cycles and injects the response error flag per command, so each sequence can be steered into either failure. A behavioural reference model follows every edge and checks that the block's outputs match it.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;

  typedef enum logic [1:0] {
    KIND_SINGLE  = 2'd0,
    KIND_ENDLESS = 2'd1,
    KIND_COUNTED = 2'd2,
    KIND_EMPTY   = 2'd3
  } xfer_kind_e;

  typedef enum logic [1:0] {
    AUTO_NONE   = 2'd0,
    AUTO_STOP   = 2'd1,
    AUTO_PRESET = 2'd2,
    AUTO_RSVD   = 2'd3
  } auto_cmd_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PRE_CMD,
    S_WAIT_PRE_RSP,
    S_MAIN_CMD,
    S_DATA,
    S_POST_CMD,
    S_WAIT_POST_RSP,
    S_DONE
  } seq_state_e;

  typedef struct packed {
    logic       multi;
    logic       dir_rd;
    logic [1:0] auto_cmd;
    logic       cnt_en;
    logic       dma_en;
  } xfer_mode_t;

  localparam int MODE_W = $bits(xfer_mode_t);

  localparam logic [2:0] SEL_MODE    = 3'd0;
  localparam logic [2:0] SEL_CMD     = 3'd1;
  localparam logic [2:0] SEL_ARG     = 3'd2;
  localparam logic [2:0] SEL_BCNT    = 3'd3;
  localparam logic [2:0] SEL_PRE_ARG = 3'd4;

  localparam logic [5:0] IDX_STOP   = 6'd12;
  localparam logic [5:0] IDX_SETCNT = 6'd23;

endpackage

// File: rtl/sdseq_regs.sv
module sdseq_regs
  import sdseq_pkg::*;
#(
  parameter int ARG_W       = 32,
  parameter int CNT_W       = 16,
  parameter int IDX_W       = 6,
  parameter bit DMA_SUPPORT = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [2:0]             wr_sel,
  input  logic [ARG_W-1:0]       wr_data,
  input  logic [ARG_W/8-1:0]     wr_be,
  input  logic                   inhibit,
  input  logic                   cnt_dec,
  output xfer_mode_t             mode,
  output logic [ARG_W-1:0]       main_arg,
  output logic [ARG_W-1:0]       pre_arg,
  output logic [CNT_W-1:0]       bcnt,
  output logic [IDX_W-1:0]       cmd_idx,
  output logic                   start,
  output logic                   illegal
);

  localparam int ARG_BYTES = ARG_W / 8;
  localparam int CNT_BYTES = CNT_W / 8;
  localparam int IDX_LSB   = 8;

  logic       wr_ok;
  logic       mode_wr;
  xfer_mode_t mode_nx;
  logic [CNT_W-1:0] bcnt_merged;

  assign wr_ok   = wr_en && !inhibit;
  assign mode_wr = wr_ok && (wr_sel == SEL_MODE) && wr_be[0];
  assign start   = wr_ok && (wr_sel == SEL_CMD) && wr_be[1];

  always_comb begin
    mode_nx        = xfer_mode_t'(wr_data[MODE_W-1:0]);
    mode_nx.dma_en = mode_nx.dma_en & DMA_SUPPORT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode    <= '0;
      illegal <= 1'b0;
    end else begin
      illegal <= mode_wr && (wr_data[3:2] == AUTO_RSVD);
      if (mode_wr) mode <= mode_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cmd_idx <= '0;
    else if (start) cmd_idx <= wr_data[IDX_LSB +: IDX_W];
  end

  for (genvar b = 0; b < ARG_BYTES; b++) begin : g_arg_byte
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        main_arg[b*8 +: 8] <= '0;
        pre_arg[b*8 +: 8]  <= '0;
      end else if (wr_ok && wr_be[b]) begin
        if (wr_sel == SEL_ARG)     main_arg[b*8 +: 8] <= wr_data[b*8 +: 8];
        if (wr_sel == SEL_PRE_ARG) pre_arg[b*8 +: 8]  <= wr_data[b*8 +: 8];
      end
    end
  end

  always_comb begin
    bcnt_merged = bcnt;
    for (int b = 0; b < CNT_BYTES; b++) begin
      if (wr_be[b]) bcnt_merged[b*8 +: 8] = wr_data[b*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bcnt <= '0;
    else if (wr_ok && (wr_sel == SEL_BCNT)) bcnt <= bcnt_merged;
    else if (cnt_dec) bcnt <= bcnt - CNT_W'(1);
  end

endmodule

// File: rtl/sdseq_kind.sv
module sdseq_kind
  import sdseq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  xfer_mode_t       mode,
  input  logic [CNT_W-1:0] bcnt,
  output xfer_kind_e       kind
);

  always_comb begin
    if (!mode.multi)       kind = KIND_SINGLE;
    else if (!mode.cnt_en) kind = KIND_ENDLESS;
    else if (bcnt != '0)   kind = KIND_COUNTED;
    else                   kind = KIND_EMPTY;
  end

endmodule

// File: rtl/sdseq_fsm.sv
module sdseq_fsm
  import sdseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  xfer_kind_e kind,
  input  auto_cmd_e  auto_sel,
  input  logic       last_blk,
  input  logic       cmd_ready,
  input  logic       rsp_valid,
  input  logic       rsp_err,
  input  logic       blk_done,
  input  logic       stop_req,
  output seq_state_e state,
  output logic       cnt_dec,
  output logic       pre_err_set,
  output logic       post_err_set
);

  seq_state_e state_nx;

  assign cnt_dec      = (state == S_DATA) && (kind == KIND_COUNTED) && blk_done;
  assign pre_err_set  = (state == S_WAIT_PRE_RSP) && rsp_valid && rsp_err;
  assign post_err_set = (state == S_WAIT_POST_RSP) && rsp_valid && rsp_err;

  always_comb begin
    state_nx = state;
    unique case (state)
      S_IDLE:
        if (start) state_nx = (auto_sel == AUTO_PRESET) ? S_PRE_CMD : S_MAIN_CMD;
      S_PRE_CMD:
        if (cmd_ready) state_nx = S_WAIT_PRE_RSP;
      S_WAIT_PRE_RSP:
        if (rsp_valid) state_nx = rsp_err ? S_DONE : S_MAIN_CMD;
      S_MAIN_CMD:
        if (cmd_ready) state_nx = (kind == KIND_EMPTY) ? S_DONE : S_DATA;
      S_DATA:
        unique case (kind)
          KIND_SINGLE:  if (blk_done) state_nx = S_DONE;
          KIND_ENDLESS: if (stop_req) state_nx = S_DONE;
          KIND_COUNTED:
            if (blk_done && last_blk)
              state_nx = (auto_sel == AUTO_STOP) ? S_POST_CMD : S_DONE;
          default:      state_nx = S_DONE;
        endcase
      S_POST_CMD:
        if (cmd_ready) state_nx = S_WAIT_POST_RSP;
      S_WAIT_POST_RSP:
        if (rsp_valid) state_nx = S_DONE;
      default:
        state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= state_nx;
  end

endmodule

// File: rtl/sd_xfer_seq.sv
module sd_xfer_seq
  import sdseq_pkg::*;
#(
  parameter int ARG_W       = 32,
  parameter int CNT_W       = 16,
  parameter int IDX_W       = 6,
  parameter int RD_W        = 16,
  parameter bit DMA_SUPPORT = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr_en,
  input  logic [2:0]         reg_wr_sel,
  input  logic [ARG_W-1:0]   reg_wr_data,
  input  logic [ARG_W/8-1:0] reg_wr_be,
  output logic [RD_W-1:0]    mode_q,
  output logic [CNT_W-1:0]   blk_cnt,
  output logic [1:0]         xfer_type,
  output logic               busy,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic [IDX_W-1:0]   cmd_index,
  output logic [ARG_W-1:0]   cmd_arg,
  input  logic               rsp_valid,
  input  logic               rsp_err,
  input  logic               blk_done,
  input  logic               stop_req,
  output logic               dma_start,
  output logic               xfer_done,
  output logic [1:0]         acmd_err,
  output logic               illegal_acmd
);

  xfer_mode_t       mode;
  logic [ARG_W-1:0] main_arg;
  logic [ARG_W-1:0] pre_arg;
  logic [IDX_W-1:0] main_idx;
  logic             start;
  logic             cnt_dec;
  logic             pre_err_set;
  logic             post_err_set;
  xfer_kind_e       kind;
  auto_cmd_e        auto_sel;
  seq_state_e       state;

  sdseq_regs #(
    .ARG_W(ARG_W), .CNT_W(CNT_W), .IDX_W(IDX_W), .DMA_SUPPORT(DMA_SUPPORT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr_en), .wr_sel(reg_wr_sel), .wr_data(reg_wr_data), .wr_be(reg_wr_be),
    .inhibit(busy), .cnt_dec(cnt_dec),
    .mode(mode), .main_arg(main_arg), .pre_arg(pre_arg), .bcnt(blk_cnt),
    .cmd_idx(main_idx), .start(start), .illegal(illegal_acmd)
  );

  sdseq_kind #(.CNT_W(CNT_W)) u_kind (
    .mode(mode), .bcnt(blk_cnt), .kind(kind)
  );

  // reserved selection behaves as no automatic command
  assign auto_sel = (auto_cmd_e'(mode.auto_cmd) == AUTO_RSVD) ? AUTO_NONE
                                                              : auto_cmd_e'(mode.auto_cmd);

  sdseq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .kind(kind), .auto_sel(auto_sel),
    .last_blk(blk_cnt == CNT_W'(1)),
    .cmd_ready(cmd_ready), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .blk_done(blk_done), .stop_req(stop_req),
    .state(state), .cnt_dec(cnt_dec),
    .pre_err_set(pre_err_set), .post_err_set(post_err_set)
  );

  assign mode_q    = {{(RD_W-MODE_W){1'b0}}, mode};
  assign xfer_type = kind;
  assign busy      = (state != S_IDLE);
  assign xfer_done = (state == S_DONE);
  assign cmd_valid = (state == S_PRE_CMD) || (state == S_MAIN_CMD) || (state == S_POST_CMD);

  always_comb begin
    unique case (state)
      S_PRE_CMD, S_WAIT_PRE_RSP: begin
        cmd_index = IDX_SETCNT;
        cmd_arg   = pre_arg;
      end
      S_POST_CMD, S_WAIT_POST_RSP: begin
        cmd_index = IDX_STOP;
        cmd_arg   = '0;
      end
      default: begin
        cmd_index = main_idx;
        cmd_arg   = main_arg;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acmd_err  <= '0;
      dma_start <= 1'b0;
    end else begin
      dma_start <= start && mode.dma_en;
      if (start) acmd_err <= '0;
      else begin
        if (pre_err_set)  acmd_err[0] <= 1'b1;
        if (post_err_set) acmd_err[1] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sdseq_checker.sv
module sdseq_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr_en,
  input logic [2:0]  reg_wr_sel,
  input logic [31:0] reg_wr_data,
  input logic [3:0]  reg_wr_be,
  input logic [15:0] mode_q,
  input logic [15:0] blk_cnt,
  input logic [1:0]  xfer_type,
  input logic        busy,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [5:0]  cmd_index,
  input logic [31:0] cmd_arg,
  input logic        rsp_valid,
  input logic        rsp_err,
  input logic        blk_done,
  input logic        xfer_done,
  input logic        illegal_acmd
);

  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[15:6] == 10'd0);

  a_r3_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy && reg_wr_en && reg_wr_sel == 3'd0 |=> $stable(mode_q));

  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_valid);

  a_r7_no_main_after_err: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !cmd_valid && cmd_index == 6'd23 && rsp_valid && rsp_err |=> !cmd_valid && xfer_done);

  a_r9_endless_count: assert property (@(posedge clk) disable iff (!rst_n)
    busy && xfer_type == 2'd1 && blk_done |=> $stable(blk_cnt));

  a_r10_illegal_cause: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_acmd |-> $past(reg_wr_en && reg_wr_sel == 3'd0 && reg_wr_be[0]
                           && reg_wr_data[3:2] == 2'b11 && !busy));

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_index) && $stable(cmd_arg));

  a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done && !busy);

endmodule

bind sd_xfer_seq sdseq_checker i_sdseq_checker (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
  .reg_wr_data(reg_wr_data), .reg_wr_be(reg_wr_be), .mode_q(mode_q),
  .blk_cnt(blk_cnt), .xfer_type(xfer_type), .busy(busy), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_index(cmd_index), .cmd_arg(cmd_arg),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .blk_done(blk_done),
  .xfer_done(xfer_done), .illegal_acmd(illegal_acmd)
);

// File: tb/test_sd_xfer_seq.sv
module test_sd_xfer_seq;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_wr_sel = '0;
  logic [31:0] reg_wr_data = '0;
  logic [3:0]  reg_wr_be = '0;
  logic [15:0] mode_q;
  logic [15:0] blk_cnt;
  logic [1:0]  xfer_type;
  logic        busy;
  logic        cmd_valid;
  logic        cmd_ready = 1'b0;
  logic [5:0]  cmd_index;
  logic [31:0] cmd_arg;
  logic        rsp_valid = 1'b0;
  logic        rsp_err = 1'b0;
  logic        blk_done = 1'b0;
  logic        stop_req = 1'b0;
  logic        dma_start;
  logic        xfer_done;
  logic [1:0]  acmd_err;
  logic        illegal_acmd;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_xfer_seq i_sd_xfer_seq (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
    .reg_wr_data(reg_wr_data), .reg_wr_be(reg_wr_be), .mode_q(mode_q),
    .blk_cnt(blk_cnt), .xfer_type(xfer_type), .busy(busy), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_index(cmd_index), .cmd_arg(cmd_arg),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .blk_done(blk_done),
    .stop_req(stop_req), .dma_start(dma_start), .xfer_done(xfer_done),
    .acmd_err(acmd_err), .illegal_acmd(illegal_acmd)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // phase: 0 idle, 1 count cmd offered, 2 count rsp awaited, 3 main offered,
  //        4 blocks flowing, 5 stop offered, 6 stop rsp awaited, 7 finishing
  int          ph = 0;
  logic [5:0]  m_mode = '0;
  logic [5:0]  m_idx = '0;
  logic [31:0] m_arg = '0, m_parg = '0;
  logic [15:0] m_cnt = '0;
  logic [1:0]  m_err = '0;
  bit          m_dma = 0, m_ill = 0;

  function automatic int kind_of(input logic [5:0] md, input logic [15:0] c);
    if (!md[5]) return 0;
    if (!md[1]) return 1;
    return (c != 0) ? 2 : 3;
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                        input logic [3:0] be);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = d[b*8 +: 8];
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; m_mode = '0; m_idx = '0; m_arg = '0; m_parg = '0;
      m_cnt = '0; m_err = '0; m_dma = 0; m_ill = 0;
    end else begin
      bit start;
      int acm;
      int k;
      start = 0; m_dma = 0; m_ill = 0;
      if (reg_wr_en && ph == 0) begin
        case (reg_wr_sel)
          3'd0: if (reg_wr_be[0]) begin
            m_mode = reg_wr_data[5:0];
            m_ill  = (reg_wr_data[3:2] == 2'b11);
          end
          3'd1: if (reg_wr_be[1]) begin m_idx = reg_wr_data[13:8]; start = 1; end
          3'd2: m_arg  = merge(m_arg, reg_wr_data, reg_wr_be);
          3'd3: m_cnt  = merge({16'd0, m_cnt}, reg_wr_data, {2'b00, reg_wr_be[1:0]}) & 32'hFFFF;
          3'd4: m_parg = merge(m_parg, reg_wr_data, reg_wr_be);
          default: ;
        endcase
      end
      acm = m_mode[3:2];
      if (acm == 3) acm = 0;
      k = kind_of(m_mode, m_cnt);
      case (ph)
        0: if (start) begin m_err = 0; m_dma = m_mode[0]; ph = (acm == 2) ? 1 : 3; end
        1: if (cmd_ready) ph = 2;
        2: if (rsp_valid) begin
             if (rsp_err) begin m_err[0] = 1; ph = 7; end else ph = 3;
           end
        3: if (cmd_ready) ph = (k == 3) ? 7 : 4;
        4: begin
             if (k == 0 && blk_done) ph = 7;
             else if (k == 1 && stop_req) ph = 7;
             else if (k == 2 && blk_done) begin
               m_cnt = m_cnt - 1;
               if (m_cnt == 0) ph = (acm == 1) ? 5 : 7;
             end
           end
        5: if (cmd_ready) ph = 6;
        6: if (rsp_valid) begin if (rsp_err) m_err[1] = 1; ph = 7; end
        default: ph = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_up();
    end
    if (rst_n) begin
      bit v;
      v = (ph == 1 || ph == 3 || ph == 5);
      check("R3 mode readback", mode_q, {10'd0, m_mode});
      check("R8 block count", blk_cnt, m_cnt);
      check("R4 transfer type", xfer_type, kind_of(m_mode, m_cnt));
      check("R13 busy", busy, ph != 0);
      check("R13 done pulse", xfer_done, ph == 7);
      check("R11 cmd valid", cmd_valid, v);
      if (v) begin
        check("R6 cmd index", cmd_index, (ph == 1) ? 23 : (ph == 5) ? 12 : m_idx);
        check("R6 cmd arg", cmd_arg, (ph == 1) ? m_parg : (ph == 5) ? 0 : m_arg);
      end
      check("R7 auto error status", acmd_err, m_err);
      check("R10 illegal pulse", illegal_acmd, m_ill);
      check("R12 dma start", dma_start, m_dma);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [2:0] sel, input logic [31:0] d, input logic [3:0] be);
    reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d; reg_wr_be = be;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_wr_be = '0;
  endtask

  task automatic serve(input string req, input logic [5:0] exp_idx, input int stall,
                       input bit give_rsp, input bit err);
    while (!cmd_valid) @(negedge clk);
    check(req, cmd_index, exp_idx);
    repeat (stall) @(negedge clk);
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
    if (give_rsp) begin
      rsp_valid = 1'b1; rsp_err = err;
      @(negedge clk);
      rsp_valid = 1'b0; rsp_err = 1'b0;
    end
  endtask

  task automatic blocks(input int n);
    for (int i = 0; i < n; i++) begin
      blk_done = 1'b1; @(negedge clk);
      blk_done = 1'b0; @(negedge clk);
    end
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 mode", mode_q, 0);
    check("R1 count", blk_cnt, 0);
    check("R1 busy", busy, 0);
    check("R1 cmd valid", cmd_valid, 0);
    check("R1 auto error", acmd_err, 0);
    check("R1 done", xfer_done, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: layout, upper bits read zero
    wr(3'd0, 32'hFFFF_FFF7, 4'hF);
    check("R2 mode layout", mode_q, 16'h0037);

    // counted run with stop command, stalled handshake (R8, R11)
    wr(3'd0, 32'h0000_0026, 4'hF);
    wr(3'd3, 32'd3, 4'hF);
    wr(3'd2, 32'hCAFE_0001, 4'hF);
    wr(3'd1, 32'h0000_1900, 4'h3);
    wr(3'd0, 32'h0000_0000, 4'hF);          // R3: ignored while busy
    check("R3 blocked write", mode_q, 16'h0026);
    serve("R5 main index", 6'd25, 3, 0, 0);
    blocks(3);
    serve("R8 stop index", 6'd12, 2, 1, 0);
    wait_idle();
    check("R8 count drained", blk_cnt, 0);

    // count command then main, clean (R6)
    wr(3'd0, 32'h0000_002A, 4'hF);
    wr(3'd3, 32'd2, 4'hF);
    wr(3'd4, 32'h0000_0002, 4'hF);
    wr(3'd1, 32'h0000_1200, 4'hF);
    serve("R6 count index", 6'd23, 1, 1, 0);
    serve("R6 main index", 6'd18, 0, 0, 0);
    blocks(2);
    wait_idle();

    // count command error: main suppressed (R7)
    wr(3'd3, 32'd4, 4'hF);
    wr(3'd1, 32'h0000_1900, 4'hF);
    serve("R7 count index", 6'd23, 0, 1, 1);
    @(negedge clk);
    check("R7 no main", cmd_valid, 0);
    wait_idle();
    check("R7 error bit", acmd_err, 2'b01);

    // endless run (R9)
    wr(3'd0, 32'h0000_0020, 4'hF);
    wr(3'd3, 32'd9, 4'hF);
    wr(3'd1, 32'h0000_1200, 4'hF);
    serve("R9 main index", 6'd18, 0, 0, 0);
    blocks(5);
    check("R9 endless busy", busy, 1);
    stop_req = 1'b1; @(negedge clk); stop_req = 1'b0;
    wait_idle();
    check("R9 count unchanged", blk_cnt, 9);

    // single block with DMA (R9, R12)
    wr(3'd0, 32'h0000_0011, 4'hF);
    wr(3'd1, 32'h0000_1100, 4'hF);
    serve("R9 single index", 6'd17, 0, 0, 0);
    blocks(1);
    wait_idle();
    check("R9 single ended", busy, 0);

    // empty counted run (R9)
    wr(3'd0, 32'h0000_0022, 4'hF);
    wr(3'd3, 32'd0, 4'hF);
    wr(3'd1, 32'h0000_1200, 4'hF);
    serve("R9 empty index", 6'd18, 1, 0, 0);
    wait_idle();

    // reserved auto selection (R10)
    wr(3'd0, 32'h0000_002E, 4'hF);
    wr(3'd3, 32'd1, 4'hF);
    wr(3'd1, 32'h0000_1900, 4'hF);
    serve("R10 runs as disabled", 6'd25, 0, 0, 0);
    blocks(1);
    @(negedge clk);
    check("R10 no stop command", cmd_valid, 0);
    wait_idle();

    // stop command error (R8)
    wr(3'd0, 32'h0000_0026, 4'hF);
    wr(3'd3, 32'd1, 4'hF);
    wr(3'd1, 32'h0000_1900, 4'hF);
    serve("R8 main index", 6'd25, 0, 0, 0);
    blocks(1);
    serve("R8 stop index", 6'd12, 0, 1, 1);
    wait_idle();
    check("R8 error bit", acmd_err, 2'b10);

    // lower-byte command write does not start (R5)
    wr(3'd1, 32'h0000_1900, 4'h1);
    @(negedge clk);
    check("R5 no start", busy, 0);

    repeat (3) @(negedge clk);
    finish_up();
  end

endmodule